// File: doc/BRIEF.md
# Stepped Sine Reference Sequencer

This block generates a low-frequency sine reference as a stream of amplitude codes for a downstream converter and smoothing filter. It runs directly on the reference clock, nominally 32 kHz. A two-bit frequency select picks how many clocks each waveform step lasts. A 16-step sequence walks nine amplitude levels up from the trough to the crest and back down, so one pass of the sequence is one sine period, centred on the 3.0 V midpoint code. The same select input has a fourth code that releases the reference node so that an external sine source can drive it.

Alongside the amplitude code the block provides a polarity flag for the falling half of the period, a one-clock pulse on every crossing of the midpoint level, and an early-warning flag that rises a programmable number of clocks before each crossing. The warning gives a relay time to switch near zero voltage. Select changes wait for the end of the running period, so the waveform never jumps in the middle of a cycle.

The control is a three-state machine. RELEASED: the output is handed over to the external source. RISE: steps 0 to 7. FALL: steps 8 to 15. The transitions are as follows. RELEASED goes to RISE on the first clock that sees a select code other than 11. RISE goes to FALL when step 7 ends. FALL goes to RISE at the end of step 15 when the select is not 11, and FALL goes to RELEASED at the end of step 15 when the select is 11. Any unused encoding falls back to RELEASED.

Top module: `sine_step_seq`

## Requirements
- R1: While reset is held low, and afterwards for as long as `freq_sel` is 11, `drive_en` is 0, `amp_code` is 3000, and `sign_neg`, `mid_cross` and `relay_warn` are 0.
- R2: Each step lasts 100, 80 or 40 clocks for `freq_sel` 00, 01 or 10, which gives periods of 1600, 1280 and 640 clocks. Consecutive `mid_cross` pulses within one setting are therefore 8 steps apart.
- R3: Step p (0 to 15) outputs level p for p ≤ 8 and level 16−p otherwise. Levels 0 to 8 map to the millivolt codes 2500, 2538, 2646, 2808, 3000, 3191, 3353, 3462 and 3500.
- R4: `sign_neg` is 1 exactly during steps 8 to 15, and it rises together with the crest code 3500.
- R5: `mid_cross` is a single-clock pulse on the first clock of step 4 and on the first clock of step 12, and `amp_code` reads 3000 whenever it is high.
- R6: `relay_warn` is high for exactly LEAD_CLKS clocks (default 160) immediately before each `mid_cross` pulse, and low in the pulse clock, provided LEAD_CLKS is below 8 steps.
- R7: A new `freq_sel` value is taken only at the end of step 15, so the running period completes with the old step length.
- R8: Code 11 seen at the end of step 15 releases the output. From the next clock, `drive_en` is 0, `amp_code` rests at 3000, and no sign, crossing or warning is produced. `drive_en` drops only from the falling half.
- R9: Leaving code 11 starts step 0 on the next clock, so the first `mid_cross` comes 4 steps after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (nominally 32 kHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_sel | input | 2 | 00/01/10 step length select, 11 releases the output |
| amp_code | output | CODE_W | Amplitude code in millivolts |
| drive_en | output | 1 | High while the block drives the reference node |
| sign_neg | output | 1 | High during the falling half of the period |
| mid_cross | output | 1 | One-clock pulse on entry to a midpoint step |
| relay_warn | output | 1 | Early warning ahead of each midpoint crossing |

## Verification
Several properties are checked on every cycle: a crossing pulse always carries the midpoint code and lasts one clock, the polarity flag rises only at the crest, release happens only out of the falling half, and a released block stays silent. The bench scenarios are the only way to show the clock counts: the step lengths for each select code, the full 16-step level sequence, the exact width of the warning window, the deferral of a select change to the next period, and the restart latency after release.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef enum logic [1:0] {
        ST_RELEASED = 2'd0,
        ST_RISE     = 2'd1,
        ST_FALL     = 2'd2
    } seq_state_t;

    localparam int          PHASE_W    = 4;
    localparam int          LEVEL_W    = 4;
    localparam int          STEPS      = 1 << PHASE_W;
    localparam int          PEAK_PHASE = STEPS / 2;
    localparam int          MID_RISE   = PEAK_PHASE / 2;
    localparam int          MID_FALL   = PEAK_PHASE + MID_RISE;
    localparam logic [1:0]  SEL_EXT    = 2'b11;
    localparam int          MID_MV     = 3000;

    function automatic logic [11:0] level_mv(input logic [LEVEL_W-1:0] lvl);
        logic [11:0] mv;
        unique case (lvl)
            4'd0:    mv = 12'd2500;
            4'd1:    mv = 12'd2538;
            4'd2:    mv = 12'd2646;
            4'd3:    mv = 12'd2808;
            4'd4:    mv = 12'd3000;
            4'd5:    mv = 12'd3191;
            4'd6:    mv = 12'd3353;
            4'd7:    mv = 12'd3462;
            4'd8:    mv = 12'd3500;
            default: mv = 12'd3000;
        endcase
        return mv;
    endfunction

endpackage

// File: rtl/ssr_step_prescaler.sv
module ssr_step_prescaler #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] div,
    output logic [CNT_W-1:0] cnt,
    output logic             tick
);
    // tick marks the last clock of the current step
    assign tick = run && (cnt == (div - CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ssr_level_map.sv
module ssr_level_map
    import ssr_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic [PHASE_W-1:0] phase,
    output logic [CODE_W-1:0]  code
);
    logic [LEVEL_W-1:0] lvl;

    // fold the 16-step phase onto the 9 levels: up 0..8, down 7..1
    always_comb begin
        if (phase <= PHASE_W'(PEAK_PHASE)) begin
            lvl = LEVEL_W'(phase);
        end else begin
            lvl = LEVEL_W'(5'(STEPS) - {1'b0, phase});
        end
        code = CODE_W'(level_mv(lvl));
    end
endmodule

// File: rtl/ssr_relay_lead.sv
module ssr_relay_lead
    import ssr_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int LEAD_CLKS = 160
) (
    input  logic               run,
    input  logic [PHASE_W-1:0] phase,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [CNT_W-1:0]   div,
    output logic               warn
);
    localparam int REM_W = CNT_W + PHASE_W;

    logic [PHASE_W-1:0] steps_left;
    logic [REM_W-1:0]   clks_left;

    // clocks until the next entry into step 4 or step 12
    always_comb begin
        steps_left = {1'b0, 3'(3'(MID_RISE) - phase[2:0])};
        if (steps_left == '0) begin
            steps_left = PHASE_W'(PEAK_PHASE);
        end
        clks_left = REM_W'(steps_left) * REM_W'(div) - REM_W'(cnt);
        warn      = run && ({{(32-REM_W){1'b0}}, clks_left} <= 32'(LEAD_CLKS));
    end
endmodule

// File: rtl/sine_step_seq.sv
module sine_step_seq
    import ssr_pkg::*;
#(
    parameter int DIV_SEL0  = 100,
    parameter int DIV_SEL1  = 80,
    parameter int DIV_SEL2  = 40,
    parameter int LEAD_CLKS = 160,
    parameter int CNT_W     = 8,
    parameter int CODE_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        freq_sel,
    output logic [CODE_W-1:0] amp_code,
    output logic              drive_en,
    output logic              sign_neg,
    output logic              mid_cross,
    output logic              relay_warn
);
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(STEPS - 1);
    localparam logic [PHASE_W-1:0] RISE_LAST  = PHASE_W'(PEAK_PHASE - 1);

    seq_state_t         state, nxt_state;
    logic [PHASE_W-1:0] phase, nxt_phase;
    logic [1:0]         sel_act, nxt_sel;
    logic [CNT_W-1:0]   div, cnt;
    logic               run, tick, lead_warn;
    logic [CODE_W-1:0]  lvl_code;

    assign run = (state != ST_RELEASED);

    always_comb begin
        unique case (sel_act)
            2'b00:   div = CNT_W'(DIV_SEL0);
            2'b01:   div = CNT_W'(DIV_SEL1);
            2'b10:   div = CNT_W'(DIV_SEL2);
            default: div = CNT_W'(DIV_SEL0);
        endcase
    end

    ssr_step_prescaler #(.CNT_W(CNT_W)) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div),
        .cnt   (cnt),
        .tick  (tick)
    );

    ssr_level_map #(.CODE_W(CODE_W)) lvl_i (
        .phase (phase),
        .code  (lvl_code)
    );

    ssr_relay_lead #(.CNT_W(CNT_W), .LEAD_CLKS(LEAD_CLKS)) lead_i (
        .run   (run),
        .phase (phase),
        .cnt   (cnt),
        .div   (div),
        .warn  (lead_warn)
    );

    // next-state logic
    always_comb begin
        nxt_state = state;
        nxt_phase = phase;
        nxt_sel   = sel_act;
        unique case (state)
            ST_RELEASED: begin
                if (freq_sel != SEL_EXT) begin
                    nxt_state = ST_RISE;
                    nxt_phase = '0;
                    nxt_sel   = freq_sel;
                end
            end
            ST_RISE: begin
                if (tick) begin
                    nxt_phase = phase + PHASE_W'(1);
                    if (phase == RISE_LAST) begin
                        nxt_state = ST_FALL;
                    end
                end
            end
            ST_FALL: begin
                if (tick) begin
                    if (phase == LAST_PHASE) begin
                        nxt_phase = '0;
                        nxt_sel   = freq_sel;
                        nxt_state = (freq_sel == SEL_EXT) ? ST_RELEASED : ST_RISE;
                    end else begin
                        nxt_phase = phase + PHASE_W'(1);
                    end
                end
            end
            default: begin
                nxt_state = ST_RELEASED;
                nxt_phase = '0;
                nxt_sel   = SEL_EXT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_RELEASED;
            phase   <= '0;
            sel_act <= SEL_EXT;
        end else begin
            state   <= nxt_state;
            phase   <= nxt_phase;
            sel_act <= nxt_sel;
        end
    end

    // outputs
    always_comb begin
        amp_code   = CODE_W'(MID_MV);
        drive_en   = 1'b0;
        sign_neg   = 1'b0;
        mid_cross  = 1'b0;
        relay_warn = lead_warn;
        unique case (state)
            ST_RISE: begin
                amp_code  = lvl_code;
                drive_en  = 1'b1;
                mid_cross = (phase == PHASE_W'(MID_RISE)) && (cnt == '0);
            end
            ST_FALL: begin
                amp_code  = lvl_code;
                drive_en  = 1'b1;
                sign_neg  = 1'b1;
                mid_cross = (phase == PHASE_W'(MID_FALL)) && (cnt == '0);
            end
            default: begin
                relay_warn = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sine_step_seq_chk.sv
module sine_step_seq_chk #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] amp_code,
    input logic              drive_en,
    input logic              sign_neg,
    input logic              mid_cross,
    input logic              relay_warn
);
    assert_cross_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mid_cross |-> (amp_code == CODE_W'(3000)));

    assert_cross_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mid_cross |=> !mid_cross);

    assert_sign_at_crest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sign_neg) |-> (amp_code == CODE_W'(3500)));

    assert_release_from_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_en) |-> $past(sign_neg));

    assert_released_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (!sign_neg && !mid_cross && !relay_warn && amp_code == CODE_W'(3000)));
endmodule

bind sine_step_seq sine_step_seq_chk #(.CODE_W(CODE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .amp_code   (amp_code),
    .drive_en   (drive_en),
    .sign_neg   (sign_neg),
    .mid_cross  (mid_cross),
    .relay_warn (relay_warn)
);

// File: tb/sine_step_seq_tb_top.sv
module sine_step_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  freq_sel = 2'b11;
    logic [11:0] amp_code;
    logic        drive_en, sign_neg, mid_cross, relay_warn;

    int n_checks = 0;
    int n_fail = 0;
    int lvl_tab [9] = '{2500, 2538, 2646, 2808, 3000, 3191, 3353, 3462, 3500};

    always #5 clk = ~clk;

    sine_step_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .freq_sel   (freq_sel),
        .amp_code   (amp_code),
        .drive_en   (drive_en),
        .sign_neg   (sign_neg),
        .mid_cross  (mid_cross),
        .relay_warn (relay_warn)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // waits for the next crossing pulse; n = negedges waited, run = warn clocks just before it
    task automatic wait_cross(output int n, output int run, output bit warn_at);
        int wr = 0;
        n = -1;
        run = 0;
        warn_at = 1'b0;
        for (int i = 1; i <= 5000; i++) begin
            @(negedge clk);
            if (mid_cross) begin
                n = i;
                run = wr;
                warn_at = relay_warn;
                break;
            end
            wr = relay_warn ? wr + 1 : 0;
        end
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        chk(drive_en == 1'b0, "R1 drive_en in reset", drive_en, 0);
        chk(amp_code == 12'd3000, "R1 amp_code in reset", amp_code, 3000);
        chk(!sign_neg && !mid_cross && !relay_warn, "R1 flags in reset",
            {sign_neg, mid_cross, relay_warn}, 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        chk(drive_en == 1'b0, "R1 held released with code 11", drive_en, 0);
    endtask

    task automatic t_start_sequence();
        int n, run;
        bit wa;
        freq_sel = 2'b00;
        wait_cross(n, run, wa);
        chk(n == 401, "R9 first crossing after start", n, 401);
        chk(amp_code == 12'd3000 && !sign_neg, "R5 crossing at rising midpoint", amp_code, 3000);
        chk(drive_en == 1'b1, "R2 driving while running", drive_en, 1);
        @(negedge clk);
        chk(mid_cross == 1'b0, "R5 single-clock pulse", mid_cross, 0);
        repeat (49) @(negedge clk);
        for (int j = 0; j < 16; j++) begin
            int p, lv;
            if (j > 0) repeat (100) @(negedge clk);
            p = (4 + j) % 16;
            lv = (p <= 8) ? p : 16 - p;
            chk(int'(amp_code) == lvl_tab[lv], $sformatf("R3 level at step %0d", p),
                amp_code, lvl_tab[lv]);
            chk(sign_neg == (p >= 8), $sformatf("R4 sign at step %0d", p), sign_neg, p >= 8);
        end
        wait_cross(n, run, wa);
        chk(n == 50, "R2 remaining clocks to crossing", n, 50);
        wait_cross(n, run, wa);
        chk(n == 800, "R2 crossing interval code 00", n, 800);
        chk(run == 160, "R6 warning width code 00", run, 160);
        chk(wa == 1'b0, "R6 warning low at crossing", wa, 0);
        chk(sign_neg == 1'b1, "R5 falling crossing has sign", sign_neg, 1);
    endtask

    task automatic t_freq_changes();
        int n, run;
        bit wa;
        freq_sel = 2'b01;
        wait_cross(n, run, wa);
        chk(n == 720, "R7 code 01 deferred to next period", n, 720);
        wait_cross(n, run, wa);
        chk(n == 640, "R2 crossing interval code 01", n, 640);
        freq_sel = 2'b10;
        wait_cross(n, run, wa);
        chk(n == 480, "R7 code 10 deferred to next period", n, 480);
        wait_cross(n, run, wa);
        chk(n == 320, "R2 crossing interval code 10", n, 320);
        chk(run == 160, "R6 warning width code 10", run, 160);
        wait_cross(n, run, wa);
        freq_sel = 2'b00;
        wait_cross(n, run, wa);
        chk(n == 320, "R7 mid-period change ignored", n, 320);
        wait_cross(n, run, wa);
        chk(n == 560, "R7 new length from next period", n, 560);
    endtask

    task automatic t_release_restart();
        int n, run, bad;
        bit wa;
        freq_sel = 2'b11;
        wait_cross(n, run, wa);
        chk(n == 800, "R8 period completes before release", n, 800);
        repeat (399) @(negedge clk);
        chk(drive_en == 1'b1, "R8 still driving on last clock", drive_en, 1);
        @(negedge clk);
        chk(drive_en == 1'b0, "R8 released after step 15", drive_en, 1'b0);
        chk(amp_code == 12'd3000 && !sign_neg, "R8 rest code when released", amp_code, 3000);
        bad = 0;
        repeat (300) begin
            @(negedge clk);
            if (mid_cross || relay_warn || drive_en) bad++;
        end
        chk(bad == 0, "R8 silent while released", bad, 0);
        freq_sel = 2'b10;
        wait_cross(n, run, wa);
        chk(n == 161, "R9 restart latency code 10", n, 161);
    endtask

    initial begin
        t_reset();
        t_start_sequence();
        t_freq_changes();
        t_release_restart();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule